// File: doc/BRIEF.md
# Configurable Oscillator Pair Response Selector

This block turns one challenged pair of ring oscillators into a single stable response bit. Each oscillator is built from a chain of stages, and each stage can route through one of two inverters, so one oscillator can take any of eight configurations, named by a 3-bit code. Frequencies are not measured here. For every configuration the block asks an external gated edge counter for one count over a fixed window and records the value returned.

A `start` pulse begins one comparison. The block first sweeps oscillator A through codes 0 to 7 in rising order, then sweeps oscillator B the same way. For each step it shows the oscillator and code, raises a one-cycle measure strobe, and waits for the count-valid pulse. After the sixteenth count it chooses, for each oscillator on its own, the code that makes the gap between the two frequencies as wide as possible. The response bit tells which oscillator was faster in that widest case. A one-cycle `done` pulse then presents the bit and the two chosen codes, and these outputs stay unchanged until the next result. Every comparison repeats the full search, so no configuration is shared between comparisons.

Top module: `osc_pair_selector`

## Requirements
- R1: After reset, `done`, `measStart`, `respBit`, `cfgA` and `cfgB` are all 0, and no measurement starts without a `start` pulse.
- R2: A `start` seen while idle launches 16 measurements in order: `oscSel`=0 (A) with `cfgCode` 0..7, then `oscSel`=1 (B) with `cfgCode` 0..7. Each launch is a one-cycle `measStart` with `oscSel` and `cfgCode` held steady until `cntValid` returns the count. The next launch follows only after that count has been taken.
- R3: Counts are 16-bit unsigned. Both differences are formed one bit wider and signed, so extreme counts of 0 and 65535 produce the right result with no wraparound.
- R4: `respBit` is 1 when (largest A count − smallest B count) is strictly greater than (largest B count − smallest A count). It is 0 otherwise, and that includes an exact tie.
- R5: When `respBit` is 1, `cfgA` is the code of A's largest count and `cfgB` is the code of B's smallest count. When `respBit` is 0, `cfgA` is the code of A's smallest count and `cfgB` is the code of B's largest count.
- R6: When several codes of one oscillator give the same extreme count, the lowest of those codes is kept.
- R7: `done` is high for exactly one cycle, together with valid `respBit`, `cfgA` and `cfgB`. These three outputs keep their values until the next `done`.
- R8: A `start` during a comparison is ignored. A `cntValid` pulse outside the wait for a count is ignored, whether the block is idle or has just launched.
- R9: Each comparison uses only its own 16 counts. A second run with new counts gives a result that depends only on the new counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one pair comparison (taken when idle) |
| cntValid | input | 1 | Count from the gated counter is ready |
| cntValue | input | 16 | Edge count for the current configuration |
| measStart | output | 1 | One-cycle request to start a window count |
| oscSel | output | 1 | Oscillator under measurement: 0 = A, 1 = B |
| cfgCode | output | 3 | Stage configuration code under measurement |
| done | output | 1 | One-cycle result strobe |
| respBit | output | 1 | Response bit |
| cfgA | output | 3 | Selected configuration code of A |
| cfgB | output | 3 | Selected configuration code of B |

## Verification
Several behaviours are checked on every cycle: `measStart` never lasts two cycles, the selection stays steady while a count is awaited, a busy `start` does not disturb the wait, each tracker's maximum never falls below its minimum, an equal count never moves a recorded code, the summed differences never go negative, `done` is a single pulse and the outputs hold between results. Only the bench scenarios can show the decision itself: the exact launch order, the choice of winning case and codes for given count patterns, tie handling, results at extreme counts, stray pulses having no effect, and a fresh result on a second run.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;

  typedef struct packed {
    logic clear;
    logic capture;
    logic decide;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DECIDE = 2'd3
  } ctrl_state_e;

endpackage

// File: rtl/osc_sel_ctrl.sv
module osc_sel_ctrl
  import osc_sel_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cntValid,
  output logic              measStart,
  output logic              oscSel,
  output logic [STAGES-1:0] cfgCode,
  output strobe_t           strobe
);

  localparam int IDX_W = STAGES + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  ctrl_state_e stateQ, stateD;
  logic [IDX_W-1:0] idxQ, idxD;

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stateD = ST_LAUNCH;
          idxD   = '0;
        end
      end
      ST_LAUNCH: stateD = ST_WAIT;
      ST_WAIT: begin
        if (cntValid) begin
          if (idxQ == LAST_IDX) begin
            stateD = ST_DECIDE;
          end else begin
            stateD = ST_LAUNCH;
            idxD   = idxQ + 1'b1;
          end
        end
      end
      ST_DECIDE: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  assign measStart      = (stateQ == ST_LAUNCH);
  assign oscSel         = idxQ[IDX_W-1];
  assign cfgCode        = idxQ[STAGES-1:0];
  assign strobe.clear   = (stateQ == ST_IDLE) && start;
  assign strobe.capture = (stateQ == ST_WAIT) && cntValid;
  assign strobe.decide  = (stateQ == ST_DECIDE);

  // R2: a launch strobe lasts one cycle
  p_launch_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> !measStart);

  // R2: selection held while the count is awaited
  p_sel_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> ($stable(cfgCode) && $stable(oscSel)));

  // R8: a start during the wait does not disturb it
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && start && !cntValid) |=> (stateQ == ST_WAIT));

endmodule

// File: rtl/osc_extreme_tracker.sv
module osc_extreme_tracker #(
  parameter int CNT_W = 16,
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             capture,
  input  logic [CFG_W-1:0] code,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] maxCnt,
  output logic [CFG_W-1:0] maxCode,
  output logic [CNT_W-1:0] minCnt,
  output logic [CFG_W-1:0] minCode
);

  logic seenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenQ   <= 1'b0;
      maxCnt  <= '0;
      maxCode <= '0;
      minCnt  <= '0;
      minCode <= '0;
    end else if (clear) begin
      seenQ <= 1'b0;
    end else if (capture) begin
      seenQ <= 1'b1;
      if (!seenQ || (cnt > maxCnt)) begin
        maxCnt  <= cnt;
        maxCode <= code;
      end
      if (!seenQ || (cnt < minCnt)) begin
        minCnt  <= cnt;
        minCode <= code;
      end
    end
  end

  // R6: extremes stay ordered once a count is recorded
  p_extremes_ordered_r6: assert property (@(posedge clk) disable iff (!rstN)
    seenQ |-> (maxCnt >= minCnt));

  // R6: an equal count keeps the earlier (lower) code
  p_tie_keeps_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !clear && seenQ && cnt == maxCnt) |=> $stable(maxCode));

endmodule

// File: rtl/osc_sel_datapath.sv
module osc_sel_datapath
  import osc_sel_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              oscSel,
  input  logic [STAGES-1:0] cfgCode,
  input  logic [CNT_W-1:0]  cntValue,
  output logic              done,
  output logic              respBit,
  output logic [STAGES-1:0] cfgA,
  output logic [STAGES-1:0] cfgB
);

  localparam int N_OSC = 2;
  localparam int DIFF_W = CNT_W + 1;

  logic [CNT_W-1:0]  maxCnt  [N_OSC];
  logic [CNT_W-1:0]  minCnt  [N_OSC];
  logic [STAGES-1:0] maxCode [N_OSC];
  logic [STAGES-1:0] minCode [N_OSC];

  for (genvar g = 0; g < N_OSC; g++) begin : g_trk
    osc_extreme_tracker #(
      .CNT_W(CNT_W),
      .CFG_W(STAGES)
    ) u_trk (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.clear),
      .capture(strobe.capture && (oscSel == 1'(g))),
      .code   (cfgCode),
      .cnt    (cntValue),
      .maxCnt (maxCnt[g]),
      .maxCode(maxCode[g]),
      .minCnt (minCnt[g]),
      .minCode(minCode[g])
    );
  end

  logic signed [DIFF_W-1:0] diffAB, diffBA;
  logic aWins;

  assign diffAB = $signed({1'b0, maxCnt[0]}) - $signed({1'b0, minCnt[1]});
  assign diffBA = $signed({1'b0, maxCnt[1]}) - $signed({1'b0, minCnt[0]});
  assign aWins  = (diffAB > diffBA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      respBit <= 1'b0;
      cfgA    <= '0;
      cfgB    <= '0;
    end else begin
      done <= strobe.decide;
      if (strobe.decide) begin
        respBit <= aWins;
        cfgA    <= aWins ? maxCode[0] : minCode[0];
        cfgB    <= aWins ? minCode[1] : maxCode[1];
      end
    end
  end

  logic signed [DIFF_W:0] diffSum;
  assign diffSum = DIFF_W'(diffAB) + DIFF_W'(diffBA);

  // R3: wide signed differences never wrap, so their sum is never negative
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |-> (diffSum >= 0));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: results hold between decisions
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.decide |=> ($stable(respBit) && $stable(cfgA) && $stable(cfgB)));

endmodule

// File: rtl/osc_pair_selector.sv
module osc_pair_selector
  import osc_sel_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cntValid,
  input  logic [CNT_W-1:0]  cntValue,
  output logic              measStart,
  output logic              oscSel,
  output logic [STAGES-1:0] cfgCode,
  output logic              done,
  output logic              respBit,
  output logic [STAGES-1:0] cfgA,
  output logic [STAGES-1:0] cfgB
);

  strobe_t strobe;

  osc_sel_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cntValid (cntValid),
    .measStart(measStart),
    .oscSel   (oscSel),
    .cfgCode  (cfgCode),
    .strobe   (strobe)
  );

  osc_sel_datapath #(.STAGES(STAGES), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .oscSel  (oscSel),
    .cfgCode (cfgCode),
    .cntValue(cntValue),
    .done    (done),
    .respBit (respBit),
    .cfgA    (cfgA),
    .cfgB    (cfgB)
  );

endmodule

// File: tb/sim_osc_pair_selector.sv
`timescale 1ns/1ps
module sim_osc_pair_selector;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cntValid = 1'b0;
  logic [15:0] cntValue = '0;
  logic measStart, oscSel, done, respBit;
  logic [2:0] cfgCode, cfgA, cfgB;

  int checks = 0;
  int errors = 0;
  logic [15:0] pat [16];

  always #2 clk = ~clk;

  osc_pair_selector u0 (
    .clk(clk), .rstN(rstN), .start(start), .cntValid(cntValid),
    .cntValue(cntValue), .measStart(measStart), .oscSel(oscSel),
    .cfgCode(cfgCode), .done(done), .respBit(respBit),
    .cfgA(cfgA), .cfgB(cfgB)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCase(input string name, input int lat, input bit busyStart, input bit stray);
    int mxA, mnA, mxB, mnB, mxAi, mnAi, mxBi, mnBi, dAB, dBA;
    int eResp, eCfgA, eCfgB, waitN;
    mxA = pat[0]; mnA = pat[0]; mxAi = 0; mnAi = 0;
    mxB = pat[8]; mnB = pat[8]; mxBi = 0; mnBi = 0;
    for (int i = 1; i < 8; i++) begin
      if (int'(pat[i]) > mxA) begin mxA = pat[i]; mxAi = i; end
      if (int'(pat[i]) < mnA) begin mnA = pat[i]; mnAi = i; end
      if (int'(pat[i+8]) > mxB) begin mxB = pat[i+8]; mxBi = i; end
      if (int'(pat[i+8]) < mnB) begin mnB = pat[i+8]; mnBi = i; end
    end
    dAB = mxA - mnB;
    dBA = mxB - mnA;
    eResp = (dAB > dBA) ? 1 : 0;
    eCfgA = eResp ? mxAi : mnAi;
    eCfgB = eResp ? mnBi : mxBi;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 16; k++) begin
      waitN = 0;
      while (!measStart && waitN < 50) begin @(negedge clk); waitN++; end
      chk("R2", {name, " launch seen"}, measStart, 1);
      chk("R2", {name, " oscSel"}, oscSel, k / 8);
      chk("R2", {name, " cfgCode"}, cfgCode, k % 8);
      if (stray && k == 4) begin cntValid = 1'b1; cntValue = 16'hFFFF; end
      @(negedge clk);
      cntValid = 1'b0;
      chk("R2", {name, " launch one cycle"}, measStart, 0);
      if (busyStart && k == 6) start = 1'b1;
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk("R2", {name, " no relaunch before count"}, measStart, 0);
      end
      start = 1'b0;
      cntValid = 1'b1; cntValue = pat[k];
      @(negedge clk);
      cntValid = 1'b0; cntValue = '0;
    end
    waitN = 0;
    while (!done && waitN < 20) begin @(negedge clk); waitN++; end
    chk("R7", {name, " done seen"}, done, 1);
    chk("R4", {name, " respBit"}, respBit, eResp);
    chk("R5", {name, " cfgA"}, cfgA, eCfgA);
    chk("R5", {name, " cfgB"}, cfgB, eCfgB);
    @(negedge clk);
    chk("R7", {name, " done one cycle"}, done, 0);
    chk("R7", {name, " respBit holds"}, respBit, eResp);
    chk("R7", {name, " cfgA holds"}, cfgA, eCfgA);
    chk("R7", {name, " cfgB holds"}, cfgB, eCfgB);
  endtask

  task automatic tReset();
    chk("R1", "done after reset", done, 0);
    chk("R1", "measStart after reset", measStart, 0);
    chk("R1", "respBit after reset", respBit, 0);
    chk("R1", "cfgA after reset", cfgA, 0);
    chk("R1", "cfgB after reset", cfgB, 0);
    repeat (5) @(negedge clk);
    chk("R1", "no launch without start", measStart, 0);
  endtask

  task automatic tAFaster();
    for (int i = 0; i < 8; i++) begin
      pat[i] = 16'(1000 + 3 * ((i * 5) % 8));
      pat[i+8] = 16'(500 + 2 * ((i * 3) % 8));
    end
    runCase("R4 A faster", 1, 1'b0, 1'b0);
    chk("R4", "A faster bit is 1", respBit, 1);
  endtask

  task automatic tBFaster();
    for (int i = 0; i < 8; i++) begin
      pat[i] = 16'(700 + ((i * 7) % 8));
      pat[i+8] = 16'(900 + 4 * ((i * 3) % 8));
    end
    runCase("R5 B faster", 2, 1'b0, 1'b0);
    chk("R4", "B faster bit is 0", respBit, 0);
  endtask

  task automatic tExtremes();
    for (int i = 0; i < 16; i++) pat[i] = 16'd30000;
    pat[3] = 16'hFFFF; pat[13] = 16'h0000;
    runCase("R3 A max B zero", 1, 1'b0, 1'b0);
    chk("R3", "extreme A wins", respBit, 1);
    for (int i = 0; i < 16; i++) pat[i] = 16'd30000;
    pat[1] = 16'h0000; pat[14] = 16'hFFFF;
    runCase("R3 B max A zero", 1, 1'b0, 1'b0);
    chk("R3", "extreme B wins", respBit, 0);
  endtask

  task automatic tTies();
    for (int i = 0; i < 16; i++) pat[i] = 16'd300;
    runCase("R6 all equal", 1, 1'b0, 1'b0);
    chk("R6", "equal gives codes 0/0 cfgA", cfgA, 0);
    chk("R6", "equal gives codes 0/0 cfgB", cfgB, 0);
    for (int i = 0; i < 16; i++) pat[i] = 16'd400;
    pat[2] = 16'd900; pat[6] = 16'd900;
    pat[9] = 16'd100; pat[12] = 16'd100;
    runCase("R6 duplicate extremes", 1, 1'b0, 1'b0);
    chk("R6", "lowest max code of A", cfgA, 2);
    chk("R6", "lowest min code of B", cfgB, 1);
  endtask

  task automatic tStray();
    logic r0;
    logic [2:0] a0, b0;
    r0 = respBit; a0 = cfgA; b0 = cfgB;
    @(negedge clk); cntValid = 1'b1; cntValue = 16'h1234;
    @(negedge clk); cntValid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", "idle cntValid no launch", measStart, 0);
    chk("R8", "idle cntValid no done", done, 0);
    chk("R8", "idle cntValid respBit kept", respBit, r0);
    chk("R8", "idle cntValid cfgA kept", cfgA, a0);
    chk("R8", "idle cntValid cfgB kept", cfgB, b0);
    for (int i = 0; i < 8; i++) begin
      pat[i] = 16'(2000 + i);
      pat[i+8] = 16'(2000 + 10 * i);
    end
    runCase("R8 busy start and stray count", 3, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R8", "no extra run after busy start", measStart, 0);
  endtask

  task automatic tRerun();
    for (int i = 0; i < 8; i++) begin
      pat[i] = 16'(5000 + 11 * ((i * 3) % 8));
      pat[i+8] = 16'(4000 + 9 * ((i * 5) % 8));
    end
    runCase("R9 first run", 1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      pat[i] = 16'(100 + ((i * 5) % 8));
      pat[i+8] = 16'(200 + ((i * 7) % 8));
    end
    runCase("R9 second run", 1, 1'b0, 1'b0);
    chk("R9", "second run uses only new counts", respBit, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAFaster();
    tBFaster();
    tExtremes();
    tTies();
    tStray();
    tRerun();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule